// File: doc/BRIEF.md
# Privilege Mode and Memory Protection Unit with Quantum Timer

This block keeps the privilege state of a small processor core. A single mode bit selects between supervisor mode (0) and user mode (1). While the core runs in user mode, each memory reference it issues is compared against a window set by a base register and a length register. Any privileged operation is trapped. This includes every I/O instruction and every write to the protection registers. In supervisor mode, references are not checked and privileged work goes ahead.

A down-counting quantum timer is loaded by supervisor software when a process is dispatched. It counts one step per clock and raises an interrupt when it reaches zero. An address fault, a privilege trap or a timer expiry moves the core to supervisor mode in hardware. Only an explicit return-to-user request, issued from supervisor mode, moves it back. At most one event is reported per cycle. An address fault wins over a privilege trap, and a privilege trap wins over the timer. A timer expiry that loses is held and reported in the next free cycle.

Top module: `prot_unit`

## Requirements
- R1: After reset the mode is supervisor (`user_mode`=0), all three event outputs are low, base and length are zero, and the timer is idle.
- R2: `ret_user` sampled in supervisor mode with no event that cycle sets `user_mode` to 1 one cycle later. `ret_user` in user mode is ignored: the mode stays 1 and no event is raised.
- R3: In user mode, a reference (`ref_valid`=1) to address A is legal when base <= A < base+length, computed without wrap-around. An illegal reference pulses `addr_fault` for one cycle on the following cycle. Legal references, and all references in supervisor mode, raise nothing.
- R4: `priv_instr` in user mode pulses `priv_trap` one cycle later. In supervisor mode it raises nothing.
- R5: Any register write (`wr_en`=1) in user mode leaves base, length and timer unchanged and pulses `priv_trap` one cycle later.
- R6: A supervisor write of value V>0 to the timer makes `timer_irq` pulse once, V cycles after the write edge. A value of 0 leaves the timer idle with no interrupt. Counting continues in both modes.
- R7: Every event output pulse is accompanied by `user_mode`=0 in the same cycle.
- R8: At most one event output is high per cycle. `addr_fault` beats `priv_trap`, and `priv_trap` beats `timer_irq`. An expiry that is suppressed is reported on the next cycle with no higher event.
- R9: `wr_sel` selects the target of a supervisor write: 0 base, 1 length, 2 timer (low TW bits of `wr_data`), 3 none (no register changes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | A memory reference is issued this cycle |
| ref_addr | input | AW | Address of the reference |
| priv_instr | input | 1 | A privileged (including I/O) instruction is issued |
| wr_en | input | 1 | Register write command |
| wr_sel | input | 2 | Write target: 0 base, 1 length, 2 timer, 3 none |
| wr_data | input | AW | Write value |
| ret_user | input | 1 | Request to return to user mode |
| addr_fault | output | 1 | One-cycle address fault pulse |
| priv_trap | output | 1 | One-cycle privilege trap pulse |
| timer_irq | output | 1 | One-cycle timer interrupt pulse |
| user_mode | output | 1 | Mode bit: 0 supervisor, 1 user |

## Verification
Every event output and the mode bit are registered, so the result of a stimulus held across a clock edge is visible in the cycle after that edge. The timer interrupt is the exception: it appears V edges after the load edge, or one edge later when a higher event holds it back. The bench drives each stimulus at the falling edge and samples shortly after the next rising edge. It counts edges from the load to the timer pulse, so each result is compared in exactly the cycle it is due. Address windows are swept one address at a time across both bounds, including a window whose end passes the top of the address space.

// File: rtl/prot_pkg.sv
// Shared encodings for the protection unit.
package prot_pkg;
    typedef enum logic [1:0] {
        SEL_BASE  = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_TIMER = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    localparam logic MODE_SUP = 1'b0;
    localparam logic MODE_USR = 1'b1;
endpackage

// File: rtl/prot_bounds.sv
// Window compare: decides whether an address lies in [base, base+len).
// Assumes nothing about the alignment of the window. The sum is one bit
// wider than the address, so a window that passes the top of the address
// space does not wrap.
module prot_bounds #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic          in_range
);
    localparam int SW = AW + 1;

    logic [SW-1:0] end_excl;

    // Exclusive upper end of the window and the two-sided compare.
    always_comb begin
        end_excl = {1'b0, base} + {1'b0, len};
        in_range = (addr >= base) && ({1'b0, addr} < end_excl);
    end
endmodule

// File: rtl/prot_timer.sv
// Quantum timer: loads a count, then decrements once per clock to zero.
// The expire flag marks the edge on which the count moves from 1 to 0.
// A load on that same edge takes precedence, and no expiry is flagged.
module prot_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expire
);
    logic [TW-1:0] cnt;

    // Flag the final decrement unless a reload overrides it.
    always_comb begin
        expire = (cnt == TW'(1)) && !load;
    end

    // Load or count down; the timer idles at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end
endmodule

// File: rtl/prot_arbiter.sv
// Event arbiter: registers one event per cycle by fixed priority.
// The order is address fault, then privilege trap, then timer.
// A timer expiry that loses is held pending until a cycle with no
// higher event. Reports whether any event is taken this cycle.
module prot_arbiter (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_req,
    input  logic trap_req,
    input  logic tmr_req,
    output logic any_evt,
    output logic addr_fault,
    output logic priv_trap,
    output logic timer_irq
);
    logic tmr_pend;
    logic tmr_any;

    // Merge a fresh expiry with one held from an earlier cycle.
    always_comb begin
        tmr_any = tmr_req || tmr_pend;
        any_evt = fault_req || trap_req || tmr_any;
    end

    // Register the winning event and hold a suppressed timer expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_fault <= 1'b0;
            priv_trap  <= 1'b0;
            timer_irq  <= 1'b0;
            tmr_pend   <= 1'b0;
        end else begin
            addr_fault <= fault_req;
            priv_trap  <= trap_req && !fault_req;
            timer_irq  <= tmr_any && !fault_req && !trap_req;
            tmr_pend   <= tmr_any && (fault_req || trap_req);
        end
    end
endmodule

// File: rtl/prot_mode.sv
// Mode bit: any event forces supervisor mode. A return request takes
// effect only from supervisor mode and only in a cycle with no event.
module prot_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic any_evt,
    input  logic ret_user,
    output logic user_mode
);
    import prot_pkg::*;

    // Update the privilege state; events take precedence over returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            user_mode <= MODE_SUP;
        end else if (any_evt) begin
            user_mode <= MODE_SUP;
        end else if (ret_user && (user_mode == MODE_SUP)) begin
            user_mode <= MODE_USR;
        end
    end
endmodule

// File: rtl/prot_unit.sv
// Protection unit top level. It holds the base and length registers,
// checks user-mode references, traps privileged operations and runs the
// quantum timer. Assumes TW <= AW; the timer is loaded from the low TW
// bits of the write data.
module prot_unit #(
    parameter int AW = 16,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_valid,
    input  logic [AW-1:0] ref_addr,
    input  logic          priv_instr,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          ret_user,
    output logic          addr_fault,
    output logic          priv_trap,
    output logic          timer_irq,
    output logic          user_mode
);
    import prot_pkg::*;

    logic [AW-1:0] base_q;
    logic [AW-1:0] len_q;
    logic          in_range;
    logic          wr_ok;
    logic          tmr_load;
    logic          tmr_expire;
    logic          fault_req;
    logic          trap_req;
    logic          any_evt;
    reg_sel_e      sel;

    // Decode writes; they are accepted only in supervisor mode.
    always_comb begin
        sel       = reg_sel_e'(wr_sel);
        wr_ok     = wr_en && (user_mode == MODE_SUP);
        tmr_load  = wr_ok && (sel == SEL_TIMER);
        fault_req = (user_mode == MODE_USR) && ref_valid && !in_range;
        trap_req  = (user_mode == MODE_USR) && (priv_instr || wr_en);
    end

    // Base and length registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
        end else if (wr_ok) begin
            if (sel == SEL_BASE)  base_q <= wr_data;
            if (sel == SEL_LIMIT) len_q  <= wr_data;
        end
    end

    prot_bounds #(.AW(AW)) u_bounds (
        .addr     (ref_addr),
        .base     (base_q),
        .len      (len_q),
        .in_range (in_range)
    );

    prot_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (wr_data[TW-1:0]),
        .expire   (tmr_expire)
    );

    prot_arbiter u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .fault_req  (fault_req),
        .trap_req   (trap_req),
        .tmr_req    (tmr_expire),
        .any_evt    (any_evt),
        .addr_fault (addr_fault),
        .priv_trap  (priv_trap),
        .timer_irq  (timer_irq)
    );

    prot_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_evt   (any_evt),
        .ret_user  (ret_user),
        .user_mode (user_mode)
    );
endmodule

// File: rtl/prot_unit_chk.sv
// Property checker for the protection unit, attached to it by bind.
// It observes ports only.
module prot_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_valid,
    input logic priv_instr,
    input logic wr_en,
    input logic ret_user,
    input logic addr_fault,
    input logic priv_trap,
    input logic timer_irq,
    input logic user_mode
);
    assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_fault, priv_trap, timer_irq}));

    assert_event_sup_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_fault || priv_trap || timer_irq) |-> !user_mode);

    assert_enter_user_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_mode) |-> $past(ret_user));

    assert_trap_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
        priv_trap |-> $past(user_mode));

    assert_trap_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        priv_trap |-> $past(priv_instr || wr_en));

    assert_fault_user_R3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_fault |-> $past(user_mode && ref_valid));
endmodule

bind prot_unit prot_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_valid  (ref_valid),
    .priv_instr (priv_instr),
    .wr_en      (wr_en),
    .ret_user   (ret_user),
    .addr_fault (addr_fault),
    .priv_trap  (priv_trap),
    .timer_irq  (timer_irq),
    .user_mode  (user_mode)
);

// File: tb/prot_unit_bench.sv
// Bench for the protection unit: sweeps windows and timer loads and
// computes the expected result for each cycle.
module prot_unit_bench;
    localparam int AW = 16;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [AW-1:0] ref_addr = '0;
    logic          priv_instr = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd3;
    logic [AW-1:0] wr_data = '0;
    logic          ret_user = 1'b0;
    logic          addr_fault;
    logic          priv_trap;
    logic          timer_irq;
    logic          user_mode;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    prot_unit #(.AW(AW), .TW(TW)) u_prot_unit (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_addr(ref_addr),
        .priv_instr(priv_instr), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ret_user(ret_user), .addr_fault(addr_fault),
        .priv_trap(priv_trap), .timer_irq(timer_irq), .user_mode(user_mode)
    );

    // Drive one cycle of inputs at the falling edge; sample after the rise.
    task automatic step(input logic rv, input logic [AW-1:0] ra, input logic pi,
                        input logic we, input logic [1:0] ws,
                        input logic [AW-1:0] wd, input logic ru);
        @(negedge clk);
        ref_valid = rv; ref_addr = ra; priv_instr = pi;
        wr_en = we; wr_sel = ws; wr_data = wd; ret_user = ru;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, 1'b0, 2'd3, '0, 1'b0);
    endtask

    // Compare all four outputs with the expected values.
    task automatic expect4(input string req, input logic ef, input logic et,
                           input logic ei, input logic em);
        n_checks++;
        if ({addr_fault, priv_trap, timer_irq, user_mode} !== {ef, et, ei, em}) begin
            n_fail++;
            $display("FAIL %s: fault/trap/irq/mode actual %b%b%b%b expected %b%b%b%b",
                     req, addr_fault, priv_trap, timer_irq, user_mode, ef, et, ei, em);
        end
    endtask

    task automatic sup_write(input logic [1:0] s, input logic [AW-1:0] d);
        step(1'b0, '0, 1'b0, 1'b1, s, d, 1'b0);
    endtask

    task automatic go_user();
        step(1'b0, '0, 1'b0, 1'b0, 2'd3, '0, 1'b1);
    endtask

    // Sweep addresses around a window, entering user mode for each one.
    task automatic sweep(input int b, input int l, input int lo, input int hi);
        for (int a = lo; a <= hi; a++) begin
            logic bad;
            bad = !((a >= b) && (a < b + l));
            go_user();
            expect4("R2", 1'b0, 1'b0, 1'b0, 1'b1);
            step(1'b1, AW'(a), 1'b0, 1'b0, 2'd3, '0, 1'b0);
            expect4("R3", bad, 1'b0, 1'b0, !bad);
            if (!bad) begin
                go_user();
                expect4("R2 ignored in user", 1'b0, 1'b0, 1'b0, 1'b1);
                step(1'b0, '0, 1'b1, 1'b0, 2'd3, '0, 1'b0);
                expect4("R4", 1'b0, 1'b1, 1'b0, 1'b0);
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        expect4("R1", 1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        idle();
        expect4("R1", 1'b0, 1'b0, 1'b0, 1'b0);

        // R1: length 0 after reset, so every user reference faults.
        go_user();
        step(1'b1, AW'(0), 1'b0, 1'b0, 2'd3, '0, 1'b0);
        expect4("R1 zero length", 1'b1, 1'b0, 1'b0, 1'b0);

        // R3/R9: window [100,150).
        sup_write(2'd0, AW'(100));
        sup_write(2'd1, AW'(50));
        sweep(100, 50, 95, 155);

        // R3: supervisor references are never checked.
        step(1'b1, AW'(5), 1'b0, 1'b0, 2'd3, '0, 1'b0);
        expect4("R3 supervisor", 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, '0, 1'b1, 1'b0, 2'd3, '0, 1'b0);
        expect4("R4 supervisor", 1'b0, 1'b0, 1'b0, 1'b0);

        // R9: selector 3 changes nothing.
        sup_write(2'd3, AW'(1000));
        sweep(100, 50, 98, 101);
        sweep(100, 50, 148, 151);

        // R5: user writes to base and timer are trapped and discarded.
        go_user();
        step(1'b0, '0, 1'b0, 1'b1, 2'd0, AW'(500), 1'b0);
        expect4("R5 base", 1'b0, 1'b1, 1'b0, 1'b0);
        sweep(100, 50, 120, 120);
        go_user();
        step(1'b0, '0, 1'b0, 1'b1, 2'd2, AW'(2), 1'b0);
        expect4("R5 timer", 1'b0, 1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) begin
            idle();
            expect4("R5 timer not loaded", 1'b0, 1'b0, 1'b0, 1'b0);
        end

        // R3: window that reaches past the top of the address space.
        sup_write(2'd0, AW'(16'hFFF0));
        sup_write(2'd1, AW'(16'h0020));
        sweep(32'hFFF0, 32'h20, 32'hFFEE, 32'hFFFF);
        sweep(32'hFFF0, 32'h20, 0, 3);

        // R6: timer load values 1..6; count edges to the pulse.
        for (int v = 1; v <= 6; v++) begin
            int seen;
            int hits;
            seen = 0;
            hits = 0;
            sup_write(2'd2, AW'(v));
            for (int k = 1; k <= v + 3; k++) begin
                idle();
                if (timer_irq) begin
                    hits++;
                    if (seen == 0) seen = k;
                end
            end
            n_checks++;
            if (seen != v || hits != 1) begin
                n_fail++;
                $display("FAIL R6: load %0d pulse at %0d (count %0d) expected at %0d once",
                         v, seen, hits, v);
            end
        end

        // R6: load zero stays idle.
        sup_write(2'd2, AW'(0));
        for (int k = 0; k < 10; k++) begin
            idle();
            expect4("R6 zero", 1'b0, 1'b0, 1'b0, 1'b0);
        end

        // R6/R7: expiry while in user mode drops to supervisor.
        sup_write(2'd2, AW'(4));
        go_user();
        idle();
        idle();
        expect4("R6 counting in user", 1'b0, 1'b0, 1'b0, 1'b1);
        idle();
        expect4("R7 timer forces sup", 1'b0, 1'b0, 1'b1, 1'b0);

        // R8: fault + trap + expiry together; then trap + expiry.
        sup_write(2'd2, AW'(3));
        go_user();
        idle();
        step(1'b1, AW'(16'h0100), 1'b1, 1'b0, 2'd3, '0, 1'b0);
        expect4("R8 fault wins", 1'b1, 1'b0, 1'b0, 1'b0);
        idle();
        expect4("R8 held expiry", 1'b0, 1'b0, 1'b1, 1'b0);
        idle();
        expect4("R8 single pulse", 1'b0, 1'b0, 1'b0, 1'b0);

        sup_write(2'd2, AW'(3));
        go_user();
        idle();
        step(1'b0, '0, 1'b1, 1'b0, 2'd3, '0, 1'b0);
        expect4("R8 trap over timer", 1'b0, 1'b1, 1'b0, 1'b0);
        idle();
        expect4("R8 held expiry", 1'b0, 1'b0, 1'b1, 1'b0);

        // R2: return request in the same cycle as an expiry is refused.
        sup_write(2'd2, AW'(1));
        go_user();
        expect4("R2 refused on expiry", 1'b0, 1'b0, 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule